// File: doc/BRIEF.md
# Microcode Sequencer with Interrupt Entry

This block steps a small processor's control unit through microprogram words held in a synchronous control store. When a new instruction arrives, the sequencer jumps to the microprogram address obtained by zero-extending the 6-bit opcode to the 7-bit micro address. No mapping table sits in that path. Each stored word holds a control field for the pipeline and the address of the word that follows it.

The address with all bits set has two roles. When it appears as a word's next address, the current instruction ends. At that instruction boundary the sequencer normally accepts the next opcode, so single-word instructions issue one per cycle without a bubble. If an interrupt is pending at that boundary, the sequencer instead runs the word stored at the all-ones address, which is the interrupt entry. That word carries an exit flag. When it ends, the sequencer returns to normal fetching and does not re-enter itself.

When no opcode is offered at a boundary, the sequencer goes idle and drives an all-zero (no-operation) control word.

Top module: `useq_core`

## Requirements
- R1: While rst_ni is low, busy_o, fetch_o and ctrl_o are all 0. After reset the block is idle and waits for a valid opcode.
- R2: On a cycle where fetch_o is 1, the next cycle has busy_o = 1 and uaddr_o = {1'b0, op_code_i} as it was sampled on the fetch cycle.
- R3: While busy, the control word for micro address a is: ctrl_o[15:9] = a XOR 7'h2A, ctrl_o[8:2] = a, ctrl_o[1] = 1, and ctrl_o[0] = 1 only when a = 127.
- R4: Opcodes 48..63 run two words: the entry word, then address 64 + opcode[3:0], which ends the instruction. Every other opcode ends after its entry word.
- R5: fetch_o is 1 only when op_valid_i is 1. At a boundary with a valid opcode and no interrupt entry, single-word instructions fetch on consecutive cycles with no idle cycle between them.
- R6: While the current word is not the last word of its instruction, fetch_o is 0 and op_code_i and op_valid_i have no effect.
- R7: At a boundary with op_valid_i = 0 and no interrupt entry, the block goes idle: busy_o = 0 and ctrl_o = 0. It stays idle until a valid opcode arrives.
- R8: When a busy, non-interrupt instruction ends while irq_pend_i = 1, the next cycle runs address 127. fetch_o stays 0 in that cycle even if op_valid_i = 1.
- R9: irq_pend_i is ignored in the middle of a multi-word instruction and while the block is idle.
- R10: When the word at address 127 ends, the block fetches a valid opcode or goes idle, whatever the value of irq_pend_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | An opcode is offered |
| op_code_i | input | 6 | Offered opcode |
| irq_pend_i | input | 1 | Interrupt waiting |
| fetch_o | output | 1 | Offered opcode is consumed this cycle |
| busy_o | output | 1 | A micro word is being executed |
| uaddr_o | output | 7 | Current micro address (valid while busy) |
| ctrl_o | output | 16 | Current control word, zero when idle |

## Verification
The one cycle where two functions compete is an instruction's final word. In that cycle a valid opcode may be offered while an interrupt is also pending, and only one of them can win. The bench drives both inputs together on exactly that cycle, after single-word and after two-word instructions, and as the interrupt word itself ends. A behavioural reference model predicts on every clock whether fetch_o rises or address 127 is entered. It also covers the cases where a pending interrupt must be ignored: in the middle of a sequence and while idle.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int OP_W    = 6;
  localparam int AW      = OP_W + 1;
  localparam int CTRL_W  = 2 * AW + 2;
  localparam int DEPTH   = 2 ** AW;
  localparam logic [AW-1:0] TERM_ADDR = {AW{1'b1}};
  localparam logic [AW-1:0] SCR_KEY   = AW'(42);

  typedef struct packed {
    logic [AW-1:0] scramble;
    logic [AW-1:0] tag;
    logic          act;
    logic          irq_exit;
  } ctrl_t;

  typedef struct packed {
    ctrl_t         ctrl;
    logic [AW-1:0] nxt;
  } uword_t;

  // control store contents, computed per address
  function automatic uword_t rom_word(logic [AW-1:0] a);
    uword_t w;
    w.ctrl.scramble = a ^ SCR_KEY;
    w.ctrl.tag      = a;
    w.ctrl.act      = 1'b1;
    w.ctrl.irq_exit = (a == TERM_ADDR);
    if (!a[AW-1] && a[OP_W-1 -: 2] == 2'b11)
      w.nxt = {1'b1, (AW-1)'(a[OP_W-3:0])};
    else
      w.nxt = TERM_ADDR;
    return w;
  endfunction
endpackage

// File: rtl/useq_rom.sv
module useq_rom
  import useq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  output uword_t        data_o
);
  uword_t mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    assign mem[i] = rom_word(AW'(i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_o <= '0;
    else         data_o <= mem[addr_i];
  end
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
(
  input  logic            busy_i,
  input  logic [AW-1:0]   word_nxt_i,
  input  logic            word_irq_exit_i,
  input  logic            op_valid_i,
  input  logic [OP_W-1:0] op_code_i,
  input  logic            irq_pend_i,
  output logic [AW-1:0]   nxt_addr_o,
  output logic            nxt_busy_o,
  output logic            fetch_o
);
  logic boundary;
  assign boundary = !busy_i || (word_nxt_i == TERM_ADDR);

  always_comb begin
    nxt_addr_o = TERM_ADDR;
    nxt_busy_o = 1'b0;
    fetch_o    = 1'b0;
    if (!boundary) begin
      nxt_addr_o = word_nxt_i;
      nxt_busy_o = 1'b1;
    end else if (busy_i && irq_pend_i && !word_irq_exit_i) begin
      nxt_addr_o = TERM_ADDR;
      nxt_busy_o = 1'b1;
    end else if (op_valid_i) begin
      nxt_addr_o = {1'b0, op_code_i};
      nxt_busy_o = 1'b1;
      fetch_o    = 1'b1;
    end
  end
endmodule

// File: rtl/useq_core.sv
module useq_core
  import useq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [OP_W-1:0]   op_code_i,
  input  logic              irq_pend_i,
  output logic              fetch_o,
  output logic              busy_o,
  output logic [AW-1:0]     uaddr_o,
  output logic [CTRL_W-1:0] ctrl_o
);
  logic          busy_q, nxt_busy, fetch_w;
  logic [AW-1:0] addr_q, nxt_addr;
  uword_t        rom_q;

  useq_next u_next (
    .busy_i          (busy_q),
    .word_nxt_i      (rom_q.nxt),
    .word_irq_exit_i (rom_q.ctrl.irq_exit),
    .op_valid_i      (op_valid_i),
    .op_code_i       (op_code_i),
    .irq_pend_i      (irq_pend_i),
    .nxt_addr_o      (nxt_addr),
    .nxt_busy_o      (nxt_busy),
    .fetch_o         (fetch_w)
  );

  useq_rom u_rom (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (nxt_addr),
    .data_o (rom_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      addr_q <= '0;
    end else begin
      busy_q <= nxt_busy;
      addr_q <= nxt_addr;
    end
  end

  assign fetch_o = fetch_w & rst_ni;
  assign busy_o  = busy_q;
  assign uaddr_o = addr_q;
  assign ctrl_o  = busy_q ? rom_q.ctrl : '0;
endmodule

// File: rtl/useq_chk.sv
module useq_chk
  import useq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              op_valid_i,
  input logic [OP_W-1:0]   op_code_i,
  input logic              irq_pend_i,
  input logic              fetch_o,
  input logic              busy_o,
  input logic [AW-1:0]     uaddr_o,
  input logic [CTRL_W-1:0] ctrl_o,
  input logic [AW-1:0]     word_nxt
);
  logic last_word;
  assign last_word = busy_o && (word_nxt == TERM_ADDR);

  assert_fetch_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_o |-> op_valid_i);
  assert_entry_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_o |=> busy_o && uaddr_o == {1'b0, $past(op_code_i)});
  assert_idle_nop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> ctrl_o == '0);
  assert_tag_match_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> ctrl_o[2 +: AW] == uaddr_o);
  assert_midseq_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && word_nxt != TERM_ADDR) |-> !fetch_o);
  assert_irq_nofetch_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_word && irq_pend_i && !ctrl_o[0]) |-> !fetch_o);
  assert_irq_entry_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_word && irq_pend_i && !ctrl_o[0]) |=> busy_o && uaddr_o == TERM_ADDR);
  assert_irq_exit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && ctrl_o[0]) |=> !(busy_o && uaddr_o == TERM_ADDR));
endmodule

bind useq_core useq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .op_valid_i (op_valid_i),
  .op_code_i  (op_code_i),
  .irq_pend_i (irq_pend_i),
  .fetch_o    (fetch_o),
  .busy_o     (busy_o),
  .uaddr_o    (uaddr_o),
  .ctrl_o     (ctrl_o),
  .word_nxt   (rom_q.nxt)
);

// File: tb/useq_core_test.sv
`timescale 1ns/1ps
module useq_core_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        op_valid_i = 1'b0;
  logic [5:0]  op_code_i = '0;
  logic        irq_pend_i = 1'b0;
  logic        fetch_o, busy_o;
  logic [6:0]  uaddr_o;
  logic [15:0] ctrl_o;

  int n_run = 0;
  int n_fail = 0;

  // reference model state
  bit       m_busy = 0;
  bit [6:0] m_addr = '0;

  always #2 clk = ~clk;

  useq_core uut (
    .clk_i(clk), .rst_ni(rst_ni), .op_valid_i(op_valid_i), .op_code_i(op_code_i),
    .irq_pend_i(irq_pend_i), .fetch_o(fetch_o), .busy_o(busy_o),
    .uaddr_o(uaddr_o), .ctrl_o(ctrl_o)
  );

  function automatic bit [6:0] nxt_of(bit [6:0] a);
    if (a < 7'd64 && a >= 7'd48) return 7'd64 + {3'b0, a[3:0]};
    return 7'd127;
  endfunction

  function automatic bit [15:0] ctrl_of(bit [6:0] a);
    return {a ^ 7'h2A, a, 1'b1, a == 7'd127};
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare, advance model
  task automatic step(string tag, bit v, bit [5:0] op, bit irq);
    bit term, e_fetch;
    op_valid_i = v; op_code_i = op; irq_pend_i = irq;
    #1;
    term = !m_busy || nxt_of(m_addr) == 7'd127;
    e_fetch = 0;
    check(tag, "busy_o", busy_o, m_busy);
    check(tag, "ctrl_o", ctrl_o, m_busy ? ctrl_of(m_addr) : 16'h0);
    if (m_busy) check(tag, "uaddr_o", uaddr_o, m_addr);
    if (!term) begin
      m_addr = nxt_of(m_addr);
    end else if (m_busy && irq && m_addr != 7'd127) begin
      m_addr = 7'd127;
    end else if (v) begin
      e_fetch = 1; m_busy = 1; m_addr = {1'b0, op};
    end else begin
      m_busy = 0;
    end
    check(tag, "fetch_o", fetch_o, e_fetch);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: held in reset with an offered opcode and interrupt
    op_valid_i = 1; op_code_i = 6'd9; irq_pend_i = 1; #1;
    check("R1", "fetch_o in reset", fetch_o, 0);
    check("R1", "busy_o in reset", busy_o, 0);
    check("R1", "ctrl_o in reset", ctrl_o, 0);
    @(negedge clk);
    check("R1", "busy_o in reset", busy_o, 0);
    rst_ni = 1;
    // R9: interrupt ignored while idle after reset
    repeat (3) step("R9", 0, 6'd0, 1);
    // R5, R2: back-to-back single-word instructions
    for (int i = 0; i < 16; i++) step("R5", 1, 6'(i), 0);
    // R4, R6: two-word opcodes, offered opcode must be ignored mid-sequence
    step("R4", 1, 6'd48, 0);
    step("R6", 1, 6'd7, 0);
    step("R4", 1, 6'd63, 0);
    step("R6", 1, 6'd2, 0);
    step("R4", 1, 6'd51, 0);
    step("R6", 0, 6'd2, 0);
    // R7: gaps with no opcode
    repeat (4) step("R7", 0, 6'd33, 0);
    step("R7", 1, 6'd33, 0);
    step("R7", 0, 6'd0, 0);
    // R8: interrupt at the end of a single-word instruction, opcode also valid
    step("R8", 1, 6'd3, 0);
    step("R8", 1, 6'd4, 1);
    step("R10", 1, 6'd5, 0);
    step("R8", 0, 6'd0, 0);
    // R9: interrupt mid-sequence ignored, taken at its end
    step("R9", 1, 6'd60, 0);
    step("R9", 1, 6'd1, 1);
    step("R8", 1, 6'd1, 1);
    // R10: interrupt held, the routine still exits into fetch
    repeat (6) step("R10", 1, 6'd12, 1);
    step("R10", 0, 6'd0, 1);
    repeat (3) step("R10", 0, 6'd0, 1);
    // R3: random traffic over the whole control store
    for (int i = 0; i < 3000; i++)
      step("R3", 1'($urandom_range(0, 3) != 0), 6'($urandom), 1'($urandom_range(0, 3) == 0));
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule